// File: doc/BRIEF.md
# Indexed Block-Transfer Register Target on I2C

This block is an I2C target that exposes a small bank of 8-bit configuration registers. Every transfer is indexed. A write transaction carries the device address, a starting offset, a byte count and then the data bytes. The data bytes land at consecutive offsets. A read transaction first sets the offset in a short write phase. It then issues a repeated start and the read address. The target answers with a byte count and then streams register bytes from the chosen offset onward, until the host refuses a byte with a NACK.

The block runs entirely on the system clock. SCL and SDA pass through two-flop synchronizers. Start and stop conditions are recognised as SDA edges while SCL is high. SDA is driven open-drain: the single `sda_oe` output pulls the line low when asserted.

The bank has nine bytes. Offset 0 is a control byte and offset 1 is a status byte whose bits 5:4 are read-only. Offset 6 holds a fixed identity value made of a revision nibble and a vendor nibble. Offset 8 holds the count that a read transaction returns first. All other offsets are spare bytes.

Top module: `i2c_blkreg_target`

## Requirements
- R1: The 7-bit device address is 0x6A, so the address byte is 0xD4 for a write and 0xD5 for a read. Both are ACKed by holding SDA low during the ninth clock. Any other address byte is NACKed, and the target then ignores the bus until the next start.
- R2: A write consists of start, 0xD4, offset N, count X, and X data bytes. The data bytes are stored at offsets N through N+X-1, and every one of these bytes is ACKed.
- R3: A data byte that arrives after X data bytes have already been received is NACKed and is not stored.
- R4: A read consists of start, 0xD4, N, a repeated start and 0xD5. The first byte returned is the value of the count byte at offset 8. The following bytes come from offsets N, N+1 and so on. The offset advances after each byte, and a host NACK ends the transfer.
- R5: After reset, offset 0 reads 0x06, offset 6 reads 0x21 (revision 2 in bits 7:4, vendor 1 in bits 3:0), offset 8 reads 0x08, and every other offset reads 0xFF.
- R6: Writes leave offset 6 unchanged in all bits. Writes leave bits 5:4 of offset 1 unchanged, and the other bits of offset 1 take the written value.
- R7: A write to offset 9 or above is ACKed and discarded. A read from offset 9 or above returns 0xFF.
- R8: A start or stop that arrives partway through a byte abandons that byte without storing it. A stop returns the target to idle. A start makes the target expect a fresh address byte.
- R9: `sda_oe` is low after reset and whenever the target is idle. It only asserts while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | Pulls SDA low when 1, otherwise SDA is released |

## Verification
The assertions check the following on every cycle:
- SDA is pulled low only while SCL is low, and never while idle.
- A stop always lands in idle, and a start always restarts address reception with an empty bit count.
- The bit count never exceeds one byte.
- The identity byte never moves.

The bench scenarios cover what only whole transactions can show:
- the ordering of count and data bytes on reads
- the NACK of surplus data bytes
- masked writes to the status byte
- discarded out-of-range writes
- bytes cut short by a stop or a repeated start, which must leave registers untouched

// File: rtl/blkreg_pkg.sv
package blkreg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK
  } phase_t;

  typedef enum logic [1:0] {
    FLD_ADDR,
    FLD_OFFSET,
    FLD_COUNT,
    FLD_DATA
  } field_t;

  // Reset value of register idx.
  function automatic logic [7:0] reg_reset_val(
    input int          idx,
    input int          ctrl_idx,
    input int          id_idx,
    input int          cnt_idx,
    input logic [7:0]  ctrl_def,
    input logic [7:0]  id_val,
    input logic [7:0]  cnt_def
  );
    if (idx == ctrl_idx) return ctrl_def;
    if (idx == id_idx)   return id_val;
    if (idx == cnt_idx)  return cnt_def;
    return 8'hFF;
  endfunction

  // Bits set to 1 keep their value on a write.
  function automatic logic [7:0] reg_keep_mask(
    input int          idx,
    input int          id_idx,
    input int          stat_idx,
    input logic [7:0]  stat_mask
  );
    if (idx == id_idx)   return 8'hFF;
    if (idx == stat_idx) return stat_mask;
    return 8'h00;
  endfunction

  function automatic field_t next_field(input field_t f);
    case (f)
      FLD_ADDR:   return FLD_OFFSET;
      FLD_OFFSET: return FLD_COUNT;
      default:    return FLD_DATA;
    endcase
  endfunction

endpackage

// File: rtl/blkreg_line_sync.sv
module blkreg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/blkreg_bank.sv
module blkreg_bank
  import blkreg_pkg::*;
#(
  parameter int         NUM_REGS  = 9,
  parameter int         CTRL_IDX  = 0,
  parameter int         STAT_IDX  = 1,
  parameter int         ID_IDX    = 6,
  parameter int         CNT_IDX   = 8,
  parameter logic [7:0] CTRL_DEF  = 8'h06,
  parameter logic [7:0] STAT_MASK = 8'h30,
  parameter logic [7:0] ID_VAL    = 8'h21,
  parameter logic [7:0] CNT_DEF   = 8'h08
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_idx,
  output logic [7:0] rd_data,
  output logic [7:0] cnt_val,
  output logic [7:0] id_byte
);

  localparam int IDXW = $clog2(NUM_REGS);

  logic [7:0] regs      [NUM_REGS];
  logic [7:0] rst_val   [NUM_REGS];
  logic [7:0] keep_mask [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_const
    assign rst_val[i]   = reg_reset_val(i, CTRL_IDX, ID_IDX, CNT_IDX,
                                        CTRL_DEF, ID_VAL, CNT_DEF);
    assign keep_mask[i] = reg_keep_mask(i, ID_IDX, STAT_IDX, STAT_MASK);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rst)
        regs[i] <= rst_val[i];
      else if (wr_en && wr_idx == 8'(i))
        regs[i] <= (regs[i] & keep_mask[i]) | (wr_data & ~keep_mask[i]);
    end
  end

  assign rd_data = (rd_idx < 8'(NUM_REGS)) ? regs[rd_idx[IDXW-1:0]] : 8'hFF;
  assign cnt_val = regs[CNT_IDX];
  assign id_byte = regs[ID_IDX];

endmodule

// File: rtl/blkreg_proto.sv
module blkreg_proto
  import blkreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [7:0] rd_idx,
  input  logic [7:0] rd_data,
  input  logic [7:0] cnt_val,
  output logic       sda_oe,
  output phase_t     phase_o,
  output logic [3:0] bitcnt_o
);

  phase_t     phase;
  field_t     field;
  logic [3:0] bitcnt;
  logic [7:0] rx_sh, tx_sh, offset, wr_left;
  logic       rd_mode, host_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      field    <= FLD_ADDR;
      bitcnt   <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      offset   <= '0;
      wr_left  <= '0;
      rd_mode  <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        phase  <= PH_RX;
        field  <= FLD_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (phase)
          PH_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              rx_sh  <= {rx_sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              case (field)
                FLD_ADDR: begin
                  if (rx_sh[7:1] == DEV_ADDR) begin
                    rd_mode <= rx_sh[0];
                    sda_oe  <= 1'b1;
                    phase   <= PH_RX_ACK;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                FLD_OFFSET: begin
                  offset <= rx_sh;
                  sda_oe <= 1'b1;
                  phase  <= PH_RX_ACK;
                end
                FLD_COUNT: begin
                  wr_left <= rx_sh;
                  sda_oe  <= 1'b1;
                  phase   <= PH_RX_ACK;
                end
                default: begin
                  if (wr_left != 8'd0) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= offset;
                    wr_data <= rx_sh;
                    offset  <= offset + 8'd1;
                    wr_left <= wr_left - 8'd1;
                    sda_oe  <= 1'b1;
                    phase   <= PH_RX_ACK;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
              endcase
            end
          end
          PH_RX_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (field == FLD_ADDR && rd_mode) begin
                tx_sh  <= cnt_val;
                sda_oe <= ~cnt_val[7];
                phase  <= PH_TX;
              end else begin
                sda_oe <= 1'b0;
                field  <= next_field(field);
                phase  <= PH_RX;
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                phase  <= PH_TX_ACK;
              end else begin
                tx_sh  <= {tx_sh[6:0], 1'b0};
                sda_oe <= ~tx_sh[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          PH_TX_ACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (host_ack) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[7];
                offset <= offset + 8'd1;
                phase  <= PH_TX;
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_idx   = offset;
  assign phase_o  = phase;
  assign bitcnt_o = bitcnt;

endmodule

// File: rtl/i2c_blkreg_target.sv
module i2c_blkreg_target
  import blkreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h6A,
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_REGS    = 9,
  parameter int         STAT_IDX    = 1,
  parameter int         ID_IDX      = 6,
  parameter int         CNT_IDX     = 8,
  parameter logic [7:0] CTRL_DEF    = 8'h06,
  parameter logic [7:0] STAT_MASK   = 8'h30,
  parameter logic [3:0] REV_ID      = 4'h2,
  parameter logic [3:0] VEN_ID      = 4'h1,
  parameter logic [7:0] CNT_DEF     = 8'h08
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  localparam logic [7:0] ID_VAL = {REV_ID, VEN_ID};

  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data, cnt_val, id_byte;
  phase_t     phase;
  logic [3:0] bitcnt;

  blkreg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  blkreg_proto #(.DEV_ADDR(DEV_ADDR)) u_proto (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
    .rd_data(rd_data), .cnt_val(cnt_val), .sda_oe(sda_oe),
    .phase_o(phase), .bitcnt_o(bitcnt)
  );

  blkreg_bank #(
    .NUM_REGS(NUM_REGS), .CTRL_IDX(0), .STAT_IDX(STAT_IDX), .ID_IDX(ID_IDX),
    .CNT_IDX(CNT_IDX), .CTRL_DEF(CTRL_DEF), .STAT_MASK(STAT_MASK),
    .ID_VAL(ID_VAL), .CNT_DEF(CNT_DEF)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .cnt_val(cnt_val), .id_byte(id_byte)
  );

endmodule

// File: rtl/blkreg_checker.sv
module blkreg_checker
  import blkreg_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input phase_t     phase,
  input logic [3:0] bitcnt,
  input logic [7:0] id_byte,
  input logic [7:0] id_exp
);

  p_reset_release_r9: assert property (@(posedge clk) rst |=> !sda_oe);

  p_pull_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  p_idle_released_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> !sda_oe);

  p_stop_idle_r8: assert property (@(posedge clk) disable iff (rst)
    stop_det && !start_det |=> phase == PH_IDLE);

  p_start_addr_r8: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (phase == PH_RX && bitcnt == 4'd0));

  p_bitcnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    bitcnt <= 4'd8);

  p_id_fixed_r6: assert property (@(posedge clk) disable iff (rst)
    id_byte == id_exp);

endmodule

bind i2c_blkreg_target blkreg_checker u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .phase(phase), .bitcnt(bitcnt),
  .id_byte(id_byte), .id_exp(ID_VAL)
);

// File: tb/i2c_blkreg_target_bench.sv
module i2c_blkreg_target_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic h_scl = 1'b1, h_sda = 1'b1;
  logic sda_oe;
  logic sda_line;
  assign sda_line = h_sda & ~sda_oe;

  i2c_blkreg_target u_i2c_blkreg_target (
    .clk(clk), .rst(rst), .scl_i(h_scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] mdl [0:8];
  logic [7:0] dbuf [0:15];
  localparam int Q = 6;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] keep_of(input int off);
    if (off == 6) return 8'hFF;
    if (off == 1) return 8'h30;
    return 8'h00;
  endfunction

  function automatic logic [7:0] mdl_rd(input int off);
    if (off < 9) return mdl[off];
    return 8'hFF;
  endfunction

  task automatic mdl_wr(input int off, input logic [7:0] d);
    if (off < 9) mdl[off] = (mdl[off] & keep_of(off)) | (d & ~keep_of(off));
  endtask

  task automatic mdl_reset();
    for (int i = 0; i < 9; i++) mdl[i] = 8'hFF;
    mdl[0] = 8'h06; mdl[6] = 8'h21; mdl[8] = 8'h08;
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    h_sda = 1'b1; qw(); h_scl = 1'b1; qw(); h_sda = 1'b0; qw(); h_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    h_sda = 1'b0; qw(); h_scl = 1'b1; qw(); h_sda = 1'b1; qw(); qw();
  endtask

  task automatic put_bit(input logic b);
    h_sda = b; qw(); h_scl = 1'b1; qw(); qw(); h_scl = 1'b0; qw();
  endtask

  task automatic get_bit(output logic b);
    h_sda = 1'b1; qw(); h_scl = 1'b1; qw(); b = sda_line; qw(); h_scl = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    acked = !a;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin get_bit(v); b[i] = v; end
    put_bit(!give_ack);
  endtask

  // R2/R3/R7: write with explicit count, nsend data bytes taken from dbuf
  task automatic wr_txn(input int off, input int cnt, input int nsend);
    bit a;
    bus_start();
    send_byte(8'hD4, a); chk(a, "R1 write address ack", 8'(a), 8'h01);
    send_byte(8'(off), a); chk(a, "R2 offset ack", 8'(a), 8'h01);
    send_byte(8'(cnt), a); chk(a, "R2 count ack", 8'(a), 8'h01);
    for (int i = 0; i < nsend; i++) begin
      send_byte(dbuf[i], a);
      if (i < cnt) begin
        chk(a, (off + i >= 9) ? "R7 out-of-range write ack" : "R2 data ack", 8'(a), 8'h01);
        mdl_wr(off + i, dbuf[i]);
      end else begin
        chk(!a, "R3 surplus byte nack", 8'(a), 8'h00);
        break;
      end
    end
    bus_stop();
  endtask

  // R4/R5/R7: indexed read of n bytes after the count byte
  task automatic rd_txn(input int off, input int n);
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD4, a); chk(a, "R1 write address ack", 8'(a), 8'h01);
    send_byte(8'(off), a); chk(a, "R4 offset ack", 8'(a), 8'h01);
    bus_start();
    send_byte(8'hD5, a); chk(a, "R1 read address ack", 8'(a), 8'h01);
    recv_byte(1'b1, b); chk(b == mdl[8], "R4 count byte first", b, mdl[8]);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(b == mdl_rd(off + i), (off + i >= 9) ? "R7 out-of-range read" : "R4 data byte", b, mdl_rd(off + i));
    end
    bus_stop();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=hung exp=done");
    finish_run();
  end

  initial begin
    bit a;
    int unsigned seed;
    mdl_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R9 released after reset", 8'(sda_oe), 8'h00);

    // R5: default contents via one block read of all nine bytes
    rd_txn(0, 9);

    // R2: plain block write then read back
    dbuf[0] = 8'h5A; dbuf[1] = 8'hC3; dbuf[2] = 8'h00; dbuf[3] = 8'h7E;
    wr_txn(0, 4, 4);
    rd_txn(0, 4);

    // R6: read-only identity byte and masked status bits
    dbuf[0] = 8'h00;
    wr_txn(6, 1, 1);
    wr_txn(1, 1, 1);
    rd_txn(1, 1);
    rd_txn(6, 1);

    // R7: writes past the bank are acknowledged and dropped
    dbuf[0] = 8'h12; dbuf[1] = 8'h34;
    wr_txn(9, 2, 2);
    rd_txn(9, 2);

    // R3: count of 2, third byte must be refused and not stored
    dbuf[0] = 8'hA1; dbuf[1] = 8'hB2; dbuf[2] = 8'hC4;
    wr_txn(3, 2, 3);
    rd_txn(3, 3);

    // R1: foreign address refused, line left released
    bus_start();
    send_byte(8'hA0, a); chk(!a, "R1 foreign address nack", 8'(a), 8'h00);
    send_byte(8'h00, a); chk(!a, "R1 ignored after nack", 8'(a), 8'h00);
    bus_stop();
    chk(sda_oe == 1'b0, "R9 idle released", 8'(sda_oe), 8'h00);

    // R8: stop in the middle of a data byte
    bus_start();
    send_byte(8'hD4, a); send_byte(8'h02, a); send_byte(8'h01, a);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    rd_txn(2, 1);

    // R8: repeated start in the middle of a data byte, then fresh address
    bus_start();
    send_byte(8'hD4, a); send_byte(8'h02, a); send_byte(8'h01, a);
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    send_byte(8'hD4, a); chk(a, "R8 address after restart", 8'(a), 8'h01);
    bus_stop();
    rd_txn(2, 1);

    // R4: count byte follows a write to offset 8
    dbuf[0] = 8'h03;
    wr_txn(8, 1, 1);
    rd_txn(5, 3);

    // constrained random mix
    seed = $urandom(32'h1D2C);
    for (int it = 0; it < 16; it++) begin
      int off, cnt;
      off = int'($urandom_range(0, 11));
      cnt = int'($urandom_range(1, 4));
      for (int k = 0; k < cnt; k++) dbuf[k] = 8'($urandom);
      wr_txn(off, cnt, cnt);
      rd_txn(int'($urandom_range(0, 10)), int'($urandom_range(1, 4)));
    end

    chk(sda_oe == 1'b0, "R9 released at end", 8'(sda_oe), 8'h00);
    finish_run();
  end

endmodule